// File: doc/BRIEF.md
# Three-Channel Sound Command DMA Sequencer

This block runs three independent command streams that program the registers of a sound generator. Each stream lives in memory as a list of 16-bit commands. A channel has a pointer, an 8-bit tick prescaler, an enable bit and a sticky interrupt flag. On every horizontal retrace pulse, each enabled channel that is not waiting out a pause reads one command through a byte-wide memory port. The low byte sits at the even pointer address and the high byte at the next address. Once all reads for that retrace are done, the captured commands are carried out one channel at a time, channel 0 first.

Seven kinds of command are handled:

- a sound register write;
- a timed pause;
- a single-level repeat counter;
- a loop-back;
- an interrupt request;
- a stop;
- reserved codes, which do nothing.

The interrupt, stop and loop-back actions are separate bits of one control opcode, so a single command can combine them. A stop leaves the pointer on the following command, so software can re-enable the channel and the stream carries on from there.

Memory reads have a fixed latency of one cycle: data for an address presented with `mem_rd` high appears on `mem_rdata` after the next rising edge. A retrace pulse that arrives while a previous retrace is still being processed is dropped.

Top module: `snd_dma_seq`

## Requirements
- R1: A CPU pointer write forces bit 0 of the pointer to zero. Each fetch reads the low byte at the pointer and the high byte at pointer+1, then advances the pointer by 2.
- R2: On a retrace pulse, every enabled channel that is not paused fetches exactly one command. After all fetches, the commands execute in ascending channel order, with at most one sound write per cycle.
- R3: Opcode 0 (bits 15:12 = 0) produces one `snd_we` pulse. `snd_reg` carries bits 11:8 of the command and `snd_data` carries bits 7:0.
- R4: Opcode 1 with a count N (bits 11:0) that is not zero stops fetches for the next N×(P+1) retraces, where P is the channel prescaler. Fetching resumes on the retrace after that. A count of zero acts as a no-operation.
- R5: Opcode 2 with a count N that is not zero loads the loop counter and marks the command after it as the loop start. The loop-back command jumps to the loop start and decrements the counter while the counter is not zero, so the body runs N+1 times. A count of zero acts as a no-operation.
- R6: Opcode 4 is a control command in which bit 0 requests loop-back, bit 4 requests an interrupt and bit 5 requests a stop. The bits combine freely, and a control command with none of these bits set does nothing.
- R7: Opcode 3 and opcodes 5 to 15 perform no action; the pointer still advances by 2.
- R8: A stop clears the channel enable bit and leaves the pointer on the next command. After the CPU enables the channel again, the next retrace executes that next command.
- R9: An interrupt sets the channel flag, which stays set until the CPU writes one to that channel's `cpu_irq_clr` bit. Clearing one flag leaves the other flags unchanged. `irq` is the OR of all flags.
- R10: A disabled channel does not fetch, its pointer does not change, and it produces no sound write.
- R11: After reset, all enables, flags and pointers are zero and `snd_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal retrace pulse |
| mem_rd | output | 1 | Memory byte read request |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| cpu_ptr_we | input | 3 | Per-channel pointer write strobe |
| cpu_ptr_wdata | input | 16 | Pointer write value |
| cpu_psc_we | input | 3 | Per-channel prescaler write strobe |
| cpu_psc_wdata | input | 8 | Prescaler write value |
| cpu_en_we | input | 1 | Write strobe for all enable bits |
| cpu_en_wdata | input | 3 | New enable bits, one per channel |
| cpu_irq_clr | input | 3 | Write one to clear a channel interrupt flag |
| chan_en | output | 3 | Channel enable bits |
| chan_ptr | output | 48 | Channel pointers, channel 0 in bits 15:0 |
| irq_flags | output | 3 | Sticky interrupt flags |
| irq | output | 1 | OR of all interrupt flags |
| snd_we | output | 1 | Sound register write strobe |
| snd_reg | output | 4 | Sound register index |
| snd_data | output | 8 | Sound register data |

## Verification
The bench checks that the loop body runs N+1 times. A design that loops N times, or that decrements the counter before testing it, gives the wrong write count and a stop at the wrong retrace. It counts the retraces a pause suppresses with a prescaler of one. An off-by-one in the tick reload, or a fetch on the retrace the pause ends, shifts the resumed write by one retrace.

Other checks target:
- the zero-count forms of pause and repeat, which must not stall or arm anything;
- the combined interrupt-and-stop code;
- reserved opcodes, which must still advance the pointer;
- resuming after a stop, which fails if the pointer was not left on the next command;
- the order of the three channels' writes within one retrace;
- clearing one flag, which fails if it disturbs the other flags.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
  localparam int INSTR_W = 16;
  localparam int ARG_W   = 12;

  localparam logic [3:0] OPC_LOAD   = 4'h0;
  localparam logic [3:0] OPC_PAUSE  = 4'h1;
  localparam logic [3:0] OPC_REPEAT = 4'h2;
  localparam logic [3:0] OPC_CTRL   = 4'h4;

  // Bit positions inside a control command
  localparam int CB_LOOP = 0;
  localparam int CB_INT  = 4;
  localparam int CB_STOP = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RLO,
    S_RHI,
    S_CAP,
    S_EXEC
  } seq_state_e;
endpackage

// File: rtl/snd_dma_chan.sv
module snd_dma_chan
  import snd_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ptr_we,
  input  logic [AW-1:0] cpu_ptr_wdata,
  input  logic          cpu_psc_we,
  input  logic [PW-1:0] cpu_psc_wdata,
  input  logic          cpu_en_we,
  input  logic          cpu_en_wdata,
  input  logic          cpu_irq_clr,
  input  logic          tick,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [7:0]    rdata,
  input  logic          exec,
  output logic          ready,
  output logic [AW-1:0] ptr,
  output logic          en,
  output logic          irq,
  output logic          snd_we,
  output logic [3:0]    snd_reg,
  output logic [7:0]    snd_data
);
  logic [AW-1:0]      ptr_q, ptr_d, lptr_q, lptr_d;
  logic [PW-1:0]      psc_q, psc_d, pscc_q, pscc_d;
  logic               en_q, en_d, irq_q, irq_d, irq_set;
  logic [INSTR_W-1:0] ins_q, ins_d;
  logic [ARG_W-1:0]   lcnt_q, lcnt_d, pause_q, pause_d;
  logic [3:0]         op;
  logic [ARG_W-1:0]   arg;

  assign op  = ins_q[15:12];
  assign arg = ins_q[ARG_W-1:0];

  always_comb begin
    ptr_d   = ptr_q;
    lptr_d  = lptr_q;
    psc_d   = psc_q;
    pscc_d  = pscc_q;
    en_d    = en_q;
    ins_d   = ins_q;
    lcnt_d  = lcnt_q;
    pause_d = pause_q;
    irq_set = 1'b0;
    // pause countdown, one prescaled tick per P+1 retraces
    if (tick && (pause_q != '0)) begin
      if (pscc_q == '0) begin
        pscc_d  = psc_q;
        pause_d = pause_q - ARG_W'(1);
      end else begin
        pscc_d = pscc_q - PW'(1);
      end
    end
    if (lo_we) ins_d[7:0] = rdata;
    if (hi_we) begin
      ins_d[15:8] = rdata;
      ptr_d       = ptr_q + AW'(2);
    end
    if (exec) begin
      case (op)
        OPC_PAUSE: if (arg != '0) begin
          pause_d = arg;
          pscc_d  = psc_q;
        end
        OPC_REPEAT: if (arg != '0) begin
          lcnt_d = arg;
          lptr_d = ptr_q;
        end
        OPC_CTRL: begin
          if (ins_q[CB_LOOP] && (lcnt_q != '0)) begin
            ptr_d  = lptr_q;
            lcnt_d = lcnt_q - ARG_W'(1);
          end
          if (ins_q[CB_INT])  irq_set = 1'b1;
          if (ins_q[CB_STOP]) en_d = 1'b0;
        end
        default: ;
      endcase
    end
    irq_d = (irq_q & ~cpu_irq_clr) | irq_set;
    // CPU writes take precedence over the sequencer
    if (cpu_ptr_we) ptr_d = {cpu_ptr_wdata[AW-1:1], 1'b0};
    if (cpu_psc_we) psc_d = cpu_psc_wdata;
    if (cpu_en_we)  en_d  = cpu_en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      lptr_q  <= '0;
      psc_q   <= '0;
      pscc_q  <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      ins_q   <= '0;
      lcnt_q  <= '0;
      pause_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      lptr_q  <= lptr_d;
      psc_q   <= psc_d;
      pscc_q  <= pscc_d;
      en_q    <= en_d;
      irq_q   <= irq_d;
      ins_q   <= ins_d;
      lcnt_q  <= lcnt_d;
      pause_q <= pause_d;
    end
  end

  assign ready    = en_q && (pause_q == '0);
  assign ptr      = ptr_q;
  assign en       = en_q;
  assign irq      = irq_q;
  assign snd_we   = exec && (op == OPC_LOAD);
  assign snd_reg  = ins_q[11:8];
  assign snd_data = ins_q[7:0];

  AST_PAUSED_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |-> (pause_q == '0)); // R4
  AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OPC_CTRL) && ins_q[CB_STOP] && !cpu_en_we) |=> !en_q); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !cpu_irq_clr) |=> irq_q); // R9
endmodule

// File: rtl/snd_dma_ctrl.sv
module snd_dma_ctrl
  import snd_dma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hsync,
  input  logic [NCH-1:0]          ready,
  input  logic [NCH-1:0][AW-1:0]  ptrs,
  output logic                    tick,
  output logic [NCH-1:0]          lo_we,
  output logic [NCH-1:0]          hi_we,
  output logic [NCH-1:0]          exec,
  output logic                    mem_rd,
  output logic [AW-1:0]           mem_addr
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [NCH-1:0] go_q, go_d;
  logic           last;

  assign last = (ch_q == LAST_CH);

  always_comb begin
    state_d  = state_q;
    ch_d     = ch_q;
    go_d     = go_q;
    tick     = 1'b0;
    lo_we    = '0;
    hi_we    = '0;
    exec     = '0;
    mem_rd   = 1'b0;
    mem_addr = '0;
    case (state_q)
      S_IDLE: if (hsync) begin
        tick    = 1'b1;
        go_d    = ready;
        ch_d    = '0;
        state_d = S_RLO;
      end
      S_RLO: begin
        if (go_q[ch_q]) begin
          mem_rd   = 1'b1;
          mem_addr = ptrs[ch_q];
          state_d  = S_RHI;
        end else if (last) begin
          ch_d    = '0;
          state_d = S_EXEC;
        end else begin
          ch_d = ch_q + CHW'(1);
        end
      end
      S_RHI: begin
        mem_rd       = 1'b1;
        mem_addr     = ptrs[ch_q] | AW'(1);
        lo_we[ch_q]  = 1'b1;
        state_d      = S_CAP;
      end
      S_CAP: begin
        hi_we[ch_q] = 1'b1;
        if (last) begin
          ch_d    = '0;
          state_d = S_EXEC;
        end else begin
          ch_d    = ch_q + CHW'(1);
          state_d = S_RLO;
        end
      end
      S_EXEC: begin
        exec[ch_q] = go_q[ch_q];
        if (last) begin
          ch_d    = '0;
          state_d = S_IDLE;
        end else begin
          ch_d = ch_q + CHW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      go_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      go_q    <= go_d;
    end
  end

  AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RLO && mem_rd) |-> !mem_addr[0]); // R1
  AST_ONE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exec)); // R2
endmodule

// File: rtl/snd_dma_seq.sv
module snd_dma_seq
  import snd_dma_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 16,
  parameter int PW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic [NCH-1:0]    cpu_ptr_we,
  input  logic [AW-1:0]     cpu_ptr_wdata,
  input  logic [NCH-1:0]    cpu_psc_we,
  input  logic [PW-1:0]     cpu_psc_wdata,
  input  logic              cpu_en_we,
  input  logic [NCH-1:0]    cpu_en_wdata,
  input  logic [NCH-1:0]    cpu_irq_clr,
  output logic [NCH-1:0]    chan_en,
  output logic [NCH*AW-1:0] chan_ptr,
  output logic [NCH-1:0]    irq_flags,
  output logic              irq,
  output logic              snd_we,
  output logic [3:0]        snd_reg,
  output logic [7:0]        snd_data
);
  logic                   tick;
  logic [NCH-1:0]         ready_w, lo_we_w, hi_we_w, exec_w, we_w;
  logic [NCH-1:0][AW-1:0] ptr_w;
  logic [3:0]             reg_w  [NCH];
  logic [7:0]             data_w [NCH];

  snd_dma_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hsync    (hsync),
    .ready    (ready_w),
    .ptrs     (ptr_w),
    .tick     (tick),
    .lo_we    (lo_we_w),
    .hi_we    (hi_we_w),
    .exec     (exec_w),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    snd_dma_chan #(.AW(AW), .PW(PW)) u_chan (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_ptr_we    (cpu_ptr_we[i]),
      .cpu_ptr_wdata (cpu_ptr_wdata),
      .cpu_psc_we    (cpu_psc_we[i]),
      .cpu_psc_wdata (cpu_psc_wdata),
      .cpu_en_we     (cpu_en_we),
      .cpu_en_wdata  (cpu_en_wdata[i]),
      .cpu_irq_clr   (cpu_irq_clr[i]),
      .tick          (tick),
      .lo_we         (lo_we_w[i]),
      .hi_we         (hi_we_w[i]),
      .rdata         (mem_rdata),
      .exec          (exec_w[i]),
      .ready         (ready_w[i]),
      .ptr           (ptr_w[i]),
      .en            (chan_en[i]),
      .irq           (irq_flags[i]),
      .snd_we        (we_w[i]),
      .snd_reg       (reg_w[i]),
      .snd_data      (data_w[i])
    );
    assign chan_ptr[i*AW +: AW] = ptr_w[i];
  end

  // at most one channel executes per cycle, so a plain select suffices
  always_comb begin
    snd_reg  = '0;
    snd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (we_w[i]) begin
        snd_reg  = reg_w[i];
        snd_data = data_w[i];
      end
    end
  end

  assign snd_we = |we_w;
  assign irq    = |irq_flags;

  AST_ONE_SND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_w)); // R2
  AST_IDLE_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en[0] && !cpu_en_we) |=> !we_w[0]); // R10
endmodule

// File: tb/test_snd_dma_seq.sv
`timescale 1ns/1ps
module test_snd_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [2:0]  cpu_ptr_we = '0;
  logic [15:0] cpu_ptr_wdata = '0;
  logic [2:0]  cpu_psc_we = '0;
  logic [7:0]  cpu_psc_wdata = '0;
  logic        cpu_en_we = 1'b0;
  logic [2:0]  cpu_en_wdata = '0;
  logic [2:0]  cpu_irq_clr = '0;
  logic [2:0]  chan_en, irq_flags;
  logic [47:0] chan_ptr;
  logic        irq, snd_we;
  logic [3:0]  snd_reg;
  logic [7:0]  snd_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  snd_dma_seq i_snd_dma_seq (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cpu_ptr_we(cpu_ptr_we), .cpu_ptr_wdata(cpu_ptr_wdata),
    .cpu_psc_we(cpu_psc_we), .cpu_psc_wdata(cpu_psc_wdata),
    .cpu_en_we(cpu_en_we), .cpu_en_wdata(cpu_en_wdata),
    .cpu_irq_clr(cpu_irq_clr), .chan_en(chan_en), .chan_ptr(chan_ptr),
    .irq_flags(irq_flags), .irq(irq), .snd_we(snd_we),
    .snd_reg(snd_reg), .snd_data(snd_data)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];

  // sound write log
  int         nlog = 0;
  logic [3:0] log_reg [0:63];
  logic [7:0] log_dat [0:63];
  always @(negedge clk) if (rst_n && snd_we) begin
    log_reg[nlog % 64] = snd_reg;
    log_dat[nlog % 64] = snd_data;
    nlog = nlog + 1;
  end

  typedef struct packed {
    logic [15:0] ins;
    logic        we;
    logic [3:0]  rg;
    logic [7:0]  dat;
    logic        en;
    logic        irq;
  } vec_t;

  // single command on channel 0: expected write, enable and flag afterwards
  localparam vec_t VEC [11] = '{
    '{16'h0A55, 1'b1, 4'hA, 8'h55, 1'b1, 1'b0},  // R3
    '{16'h0F00, 1'b1, 4'hF, 8'h00, 1'b1, 1'b0},  // R3
    '{16'h4000, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0},  // R6
    '{16'h3ABC, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0},  // R7
    '{16'h7123, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0},  // R7
    '{16'h4010, 1'b0, 4'h0, 8'h00, 1'b1, 1'b1},  // R6 R9
    '{16'h4020, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0},  // R6 R8
    '{16'h4030, 1'b0, 4'h0, 8'h00, 1'b0, 1'b1},  // R6
    '{16'h1000, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0},  // R4
    '{16'h2000, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0},  // R5
    '{16'h4001, 1'b0, 4'h0, 8'h00, 1'b1, 1'b0}   // R5
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put16(input int a, input logic [15:0] v);
    mem[a[9:0]]     = v[7:0];
    mem[a[9:0] + 1] = v[15:8];
  endtask

  task automatic set_ptr(input int ch, input logic [15:0] v);
    @(negedge clk); cpu_ptr_we[ch] = 1'b1; cpu_ptr_wdata = v;
    @(negedge clk); cpu_ptr_we = '0;
  endtask

  task automatic set_psc(input int ch, input logic [7:0] v);
    @(negedge clk); cpu_psc_we[ch] = 1'b1; cpu_psc_wdata = v;
    @(negedge clk); cpu_psc_we = '0;
  endtask

  task automatic set_en(input logic [2:0] m);
    @(negedge clk); cpu_en_we = 1'b1; cpu_en_wdata = m;
    @(negedge clk); cpu_en_we = 1'b0;
  endtask

  task automatic clr_irq(input logic [2:0] m);
    @(negedge clk); cpu_irq_clr = m;
    @(negedge clk); cpu_irq_clr = '0;
  endtask

  task automatic retrace();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  function automatic logic [15:0] ptr_of(input int ch);
    return chan_ptr[ch*16 +: 16];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(chan_en == 3'b000, "R11 enables", int'(chan_en), 0);
    chk(irq_flags == 3'b000 && !irq, "R11 flags", int'(irq_flags), 0);
    chk(chan_ptr == '0, "R11 pointers", int'(chan_ptr[31:0]), 0);
    chk(!snd_we, "R11 write strobe", int'(snd_we), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table on channel 0
    for (int i = 0; i < 11; i++) begin
      put16(16'h100, VEC[i].ins);
      set_ptr(0, 16'h0100);
      set_en(3'b001);
      clr_irq(3'b111);
      base = nlog;
      retrace();
      chk((nlog - base) == int'(VEC[i].we), "R3 write count", nlog - base, int'(VEC[i].we));
      if (VEC[i].we && nlog > base) begin
        chk(log_reg[(nlog-1)%64] == VEC[i].rg, "R3 register index",
            int'(log_reg[(nlog-1)%64]), int'(VEC[i].rg));
        chk(log_dat[(nlog-1)%64] == VEC[i].dat, "R3 data",
            int'(log_dat[(nlog-1)%64]), int'(VEC[i].dat));
      end
      chk(chan_en[0] == VEC[i].en, "R6 R8 enable after command", int'(chan_en[0]), int'(VEC[i].en));
      chk(irq_flags[0] == VEC[i].irq, "R6 R9 flag after command", int'(irq_flags[0]), int'(VEC[i].irq));
      chk(ptr_of(0) == 16'h0102, "R1 R7 pointer advance", int'(ptr_of(0)), 16'h0102);
    end
    clr_irq(3'b111);

    // R1 pointer alignment
    set_ptr(1, 16'h0123);
    chk(ptr_of(1) == 16'h0122, "R1 odd pointer write", int'(ptr_of(1)), 16'h0122);

    // R10 disabled channels
    put16(16'h122, 16'h0111);
    set_en(3'b000);
    base = nlog;
    retrace();
    chk(nlog == base, "R10 no write when disabled", nlog - base, 0);
    chk(ptr_of(1) == 16'h0122, "R10 pointer frozen", int'(ptr_of(1)), 16'h0122);

    // R2 channel order
    put16(16'h140, 16'h0111); put16(16'h160, 16'h0222); put16(16'h180, 16'h0333);
    set_ptr(0, 16'h0140); set_ptr(1, 16'h0160); set_ptr(2, 16'h0180);
    set_en(3'b111);
    base = nlog;
    retrace();
    chk(nlog - base == 3, "R2 one fetch per channel", nlog - base, 3);
    chk(log_reg[base%64] == 4'h1 && log_reg[(base+1)%64] == 4'h2 && log_reg[(base+2)%64] == 4'h3,
        "R2 channel order",
        int'({log_reg[base%64], log_reg[(base+1)%64], log_reg[(base+2)%64]}), 12'h123);
    set_en(3'b000);

    // R5 repeat 3 runs body four times, R8 stop then resume
    put16(16'h200, 16'h2003); put16(16'h202, 16'h0101);
    put16(16'h204, 16'h4001); put16(16'h206, 16'h4020);
    put16(16'h208, 16'h0709);
    set_ptr(0, 16'h0200);
    set_en(3'b001);
    base = nlog;
    begin
      int n = 0;
      while (chan_en[0] && n < 20) begin
        retrace();
        n++;
      end
      chk(n == 10, "R5 retraces until stop", n, 10);
    end
    chk(nlog - base == 4, "R5 body runs N+1 times", nlog - base, 4);
    chk(ptr_of(0) == 16'h0208, "R8 pointer after stop", int'(ptr_of(0)), 16'h0208);
    set_en(3'b001);
    base = nlog;
    retrace();
    chk(nlog - base == 1 && log_reg[base%64] == 4'h7 && log_dat[base%64] == 8'h09,
        "R8 resume executes next", int'({log_reg[base%64], log_dat[base%64]}), 12'h709);

    // R5 repeat 0 is a no-operation
    put16(16'h240, 16'h2000); put16(16'h242, 16'h0102);
    put16(16'h244, 16'h4001); put16(16'h246, 16'h4020);
    set_ptr(0, 16'h0240);
    set_en(3'b001);
    base = nlog;
    for (int k = 0; k < 4; k++) retrace();
    chk(nlog - base == 1, "R5 repeat zero", nlog - base, 1);
    chk(!chan_en[0] && ptr_of(0) == 16'h0248, "R5 repeat zero end pointer", int'(ptr_of(0)), 16'h0248);

    // R4 pause 2 with prescaler 1 skips four retraces
    set_psc(0, 8'd1);
    put16(16'h280, 16'h1002); put16(16'h282, 16'h0203);
    set_ptr(0, 16'h0280);
    set_en(3'b001);
    base = nlog;
    for (int k = 0; k < 5; k++) retrace();
    chk(nlog == base && ptr_of(0) == 16'h0282, "R4 no fetch while paused", int'(ptr_of(0)), 16'h0282);
    retrace();
    chk(nlog - base == 1 && log_reg[base%64] == 4'h2, "R4 fetch after pause", nlog - base, 1);
    chk(ptr_of(0) == 16'h0284, "R4 pointer after pause", int'(ptr_of(0)), 16'h0284);
    set_en(3'b000);

    // R9 flags per channel
    put16(16'h2C0, 16'h4010); put16(16'h2E0, 16'h4010);
    set_ptr(0, 16'h02C0); set_ptr(1, 16'h02E0);
    set_en(3'b011);
    retrace();
    chk(irq_flags == 3'b011 && irq, "R9 flags set", int'(irq_flags), 3);
    clr_irq(3'b001);
    chk(irq_flags == 3'b010 && irq, "R9 clear one flag", int'(irq_flags), 2);
    clr_irq(3'b010);
    chk(irq_flags == 3'b000 && !irq, "R9 all clear", int'(irq_flags), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule